// File: doc/BRIEF.md
# Receive Data Delay Calibrator

This block is a hardware sequencer that picks the sampling delay for serial read data returned by an external device. After a one-cycle start pulse it sweeps the four delay settings in ascending order (0, 1, 2, 3, standing for 0, 2, 4 and 6 ns of added input delay). For each setting it first drives the delay select output and then issues one read of a fixed test register over a request/response handshake. Each answer is compared with a known constant, and the result goes into a 4-bit pass mask.

When the sweep is over, the mask is mapped to a final setting. A single pass picks that setting. Three passes pick the middle one. Four passes pick setting 1. Two adjacent passes prefer the setting at the edge of the range, and the middle pair picks the lower one. An empty mask or a mask with a gap is a failure. A failure raises error together with done and parks the select at 0. If no response comes within a bounded number of cycles, that setting counts as failed.

The delay line and the read transport lie outside the block.

Top module: `rx_dly_calib`

## Requirements
- R1: After reset, busy_o, done_o, err_o and rd_req_o are 0 and dly_sel_o is 0.
- R2: A start pulse starts a sweep in which rd_req_o pulses for one cycle exactly four times, with dly_sel_o equal to 0, 1, 2, 3 in turn and held stable from the cycle before each pulse. rd_addr_o equals the TEST_ADDR parameter during each pulse.
- R3: Mask bit i (the bit for setting i, bit 0 for setting 0) is set only when the response data for setting i equals the EXP_VAL parameter. Any other value clears it.
- R4: A mask with exactly one bit set selects that setting.
- R5: Mask 4'b0011 selects 0, 4'b0110 selects 1 and 4'b1100 selects 3.
- R6: Mask 4'b0111 selects 1 and 4'b1110 selects 2.
- R7: Mask 4'b1111 selects 1.
- R8: An empty or non-contiguous mask ends the sweep with done_o and err_o both 1 and dly_sel_o at 0.
- R9: The response may arrive in any of the first TIMEOUT_CYC cycles after the request cycle and is still counted. If none arrives within that window, the bit is cleared and the sweep moves to the next setting.
- R10: A start pulse while busy_o is 1 is ignored; the sweep continues with the next setting.
- R11: At the end of a sweep done_o rises. done_o, err_o and dly_sel_o then hold until the next start pulse, which clears done_o and err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle calibration start pulse |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Test register address |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | DW | Read response data |
| dly_sel_o | output | 2 | Delay setting select |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Calibration finished |
| err_o | output | 1 | Calibration failed (valid with done_o) |

## Verification
All sixteen pass masks are driven directly. This separates every selection case: each single pass, the edge preference for pairs, the middle pick for triples and for all four, and every gapped or empty mask that must fail. Random runs then mix wrong data values with response delays up to the timeout boundary, so that a late but valid answer can be told apart from a silent one. Silent settings are injected to exercise the timeout path. A stray start during the sweep shows whether the sequence restarts, because a restart would make the next select value 0 instead of the next setting.

// File: rtl/rx_dly_calib_pkg.sv
package rx_dly_calib_pkg;
  localparam int unsigned NUM_SET = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_SET);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET,
    ST_REQ,
    ST_WAIT,
    ST_DECIDE,
    ST_DONE
  } cal_state_e;
endpackage

// File: rtl/rx_dly_calib_timer.sv
module rx_dly_calib_timer #(
  parameter int unsigned TIMEOUT_CYC = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (!expired_o)        cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/rx_dly_calib_map.sv
module rx_dly_calib_map
  import rx_dly_calib_pkg::*;
(
  input  logic [NUM_SET-1:0] mask_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic               fail_o
);
  always_comb begin
    sel_o  = '0;
    fail_o = 1'b0;
    unique case (mask_i)
      4'b0001: sel_o = 2'd0;
      4'b0010: sel_o = 2'd1;
      4'b0100: sel_o = 2'd2;
      4'b1000: sel_o = 2'd3;
      4'b0011: sel_o = 2'd0; // edge of range
      4'b0110: sel_o = 2'd1; // no edge: lower
      4'b1100: sel_o = 2'd3; // edge of range
      4'b0111: sel_o = 2'd1;
      4'b1110: sel_o = 2'd2;
      4'b1111: sel_o = 2'd1; // lower middle
      default: fail_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/rx_dly_calib_seq.sv
module rx_dly_calib_seq
  import rx_dly_calib_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter logic [DW-1:0] EXP_VAL = 16'h5AA5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               rsp_valid_i,
  input  logic [DW-1:0]      rsp_data_i,
  input  logic               expired_i,
  input  logic [SEL_W-1:0]   map_sel_i,
  input  logic               map_fail_i,
  output logic [NUM_SET-1:0] mask_o,
  output logic               wait_o,
  output logic               req_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  cal_state_e         state_q, state_d;
  logic [SEL_W-1:0]   idx_q;
  logic [NUM_SET-1:0] mask_q;
  logic [SEL_W-1:0]   res_q;
  logic               err_q;
  logic               step;
  logic               last;

  assign step = (state_q == ST_WAIT) && (rsp_valid_i || expired_i);
  assign last = (idx_q == SEL_W'(NUM_SET - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = ST_SET;
      ST_SET:           state_d = ST_REQ;
      ST_REQ:           state_d = ST_WAIT;
      ST_WAIT:          if (step) state_d = last ? ST_DECIDE : ST_SET;
      ST_DECIDE:        state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mask_q  <= '0;
      res_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_IDLE || state_q == ST_DONE) && start_i) begin
        idx_q  <= '0;
        mask_q <= '0;
        err_q  <= 1'b0;
      end
      if (step) begin
        mask_q[idx_q] <= rsp_valid_i && (rsp_data_i == EXP_VAL);
        if (!last) idx_q <= idx_q + 1'b1;
      end
      if (state_q == ST_DECIDE) begin
        res_q <= map_fail_i ? '0 : map_sel_i;
        err_q <= map_fail_i;
      end
    end
  end

  assign mask_o = mask_q;
  assign wait_o = (state_q == ST_WAIT);
  assign req_o  = (state_q == ST_REQ);
  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = done_o && err_q;
  assign sel_o  = busy_o ? idx_q : res_q;
endmodule

// File: rtl/rx_dly_calib.sv
module rx_dly_calib
  import rx_dly_calib_pkg::*;
#(
  parameter int unsigned   DW          = 16,
  parameter int unsigned   AW          = 16,
  parameter logic [DW-1:0] EXP_VAL     = 16'h5AA5,
  parameter logic [AW-1:0] TEST_ADDR   = 16'h0104,
  parameter int unsigned   TIMEOUT_CYC = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_rsp_valid_i,
  input  logic [DW-1:0] rd_rsp_data_i,
  output logic [1:0]    dly_sel_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  logic [NUM_SET-1:0] mask;
  logic [SEL_W-1:0]   map_sel;
  logic               map_fail;
  logic               waiting;
  logic               expired;

  rx_dly_calib_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (waiting),
    .expired_o (expired)
  );

  rx_dly_calib_map u_map (
    .mask_i (mask),
    .sel_o  (map_sel),
    .fail_o (map_fail)
  );

  rx_dly_calib_seq #(.DW(DW), .EXP_VAL(EXP_VAL)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rsp_valid_i (rd_rsp_valid_i),
    .rsp_data_i  (rd_rsp_data_i),
    .expired_i   (expired),
    .map_sel_i   (map_sel),
    .map_fail_i  (map_fail),
    .mask_o      (mask),
    .wait_o      (waiting),
    .req_o       (rd_req_o),
    .sel_o       (dly_sel_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  assign rd_addr_o = TEST_ADDR;
endmodule

// File: rtl/rx_dly_calib_chk.sv
module rx_dly_calib_chk #(
  parameter int unsigned TIMEOUT_CYC = 256
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_req_o,
  input logic       rd_rsp_valid_i,
  input logic [1:0] dly_sel_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);
  int unsigned gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 gap_q <= 0;
    else if (rd_req_o || !busy_o) gap_q <= 0;
    else if (gap_q < TIMEOUT_CYC + 8) gap_q <= gap_q + 1;
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  // R2
  sel_settled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (busy_o && $stable(dly_sel_o)));

  // R8
  err_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && dly_sel_o == 2'd0));

  // R11
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  // R11
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !busy_o) |=> (done_o || busy_o));

  // R9
  timeout_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= TIMEOUT_CYC + 2);
endmodule

bind rx_dly_calib rx_dly_calib_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_req_o       (rd_req_o),
  .rd_rsp_valid_i (rd_rsp_valid_i),
  .dly_sel_o      (dly_sel_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_o          (err_o)
);

// File: tb/tb_rx_dly_calib.sv
module tb_rx_dly_calib;
  localparam int unsigned   DW   = 16;
  localparam int unsigned   AW   = 16;
  localparam logic [DW-1:0] EXP  = 16'h5AA5;
  localparam logic [AW-1:0] ADDR = 16'h0104;
  localparam int unsigned   TO   = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_rsp_valid_i = 1'b0;
  logic [DW-1:0] rd_rsp_data_i = '0;
  logic [1:0]    dly_sel_o;
  logic          busy_o, done_o, err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  rx_dly_calib #(.DW(DW), .AW(AW), .EXP_VAL(EXP), .TEST_ADDR(ADDR), .TIMEOUT_CYC(TO)) dut (
    .clk_i, .rst_ni, .start_i, .rd_req_o, .rd_addr_o, .rd_rsp_valid_i,
    .rd_rsp_data_i, .dly_sel_o, .busy_o, .done_o, .err_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected selection, derived from the contiguity rule
  function automatic void model(input logic [3:0] m, output int sel, output int fail);
    int lo = -1, hi = -1, n = 0;
    for (int i = 0; i < 4; i++) if (m[i]) begin
      if (lo < 0) lo = i;
      hi = i;
      n++;
    end
    sel = 0;
    fail = 0;
    if (n == 0 || (hi - lo + 1) != n) fail = 1;
    else if (n == 1) sel = lo;
    else if (n == 2) sel = (lo == 0) ? 0 : (hi == 3) ? 3 : lo;
    else if (n == 3) sel = lo + 1;
    else sel = 1;
  endfunction

  task automatic wait_req(output bit ok);
    int k = 0;
    ok = 1;
    while (!rd_req_o) begin
      @(negedge clk_i);
      k++;
      if (k > 4 * TO) begin ok = 0; return; end
    end
  endtask

  // pass: bits answered with EXP; mute: bits never answered
  // dmax=0 means answer at the last allowed cycle
  task automatic run_cal(input logic [3:0] pass, input logic [3:0] mute,
                         input int dmax, input bit inject);
    bit ok;
    int k, sel, fail, d;
    logic [3:0] eff;
    eff = pass & ~mute;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk("R11 done cleared by start", done_o, 0);
    for (int i = 0; i < 4; i++) begin
      wait_req(ok);
      chk("R2 request issued", ok, 1);
      if (!ok) return;
      chk("R2 select per setting", dly_sel_o, i);
      chk("R2 test address", rd_addr_o, ADDR);
      d = (dmax == 0) ? TO : 1 + ($urandom % dmax);
      if (inject && i == 1) start_i = 1'b1; // R10
      @(negedge clk_i);
      start_i = 1'b0;
      if (!mute[i]) begin
        repeat (d - 1) @(negedge clk_i);
        rd_rsp_valid_i = 1'b1;
        rd_rsp_data_i  = pass[i] ? EXP : (EXP ^ DW'(1 + ($urandom % 16'hFFFE)));
        @(negedge clk_i);
        rd_rsp_valid_i = 1'b0;
        rd_rsp_data_i  = '0;
      end
    end
    k = 0;
    while (!done_o && k < 4 * TO) begin @(negedge clk_i); k++; end
    model(eff, sel, fail);
    chk("R11 done raised", done_o, 1);
    if (fail) begin
      chk("R8 error on bad mask", err_o, 1);
      chk("R8 select parked", dly_sel_o, 0);
    end else begin
      chk("R3 R4 R5 R6 R7 no error", err_o, 0);
      chk("R3 R4 R5 R6 R7 selection", dly_sel_o, sel);
    end
    repeat (3) @(negedge clk_i);
    chk("R11 done held", done_o, 1);
    chk("R11 select held", dly_sel_o, fail ? 0 : sel);
    chk("R10 R2 no extra request", rd_req_o, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 done after reset", done_o, 0);
    chk("R1 err after reset", err_o, 0);
    chk("R1 req after reset", rd_req_o, 0);
    chk("R1 select after reset", dly_sel_o, 0);

    // R4 R5 R6 R7 R8: every mask directly
    for (int m = 0; m < 16; m++) run_cal(4'(m), 4'b0000, 3, 0);
    // R9: late answer at the window's last cycle still counts
    run_cal(4'b1111, 4'b0000, 0, 0);
    run_cal(4'b0110, 4'b0000, 0, 0);
    // R9: silent settings time out as failures
    run_cal(4'b1111, 4'b1000, 2, 0);
    run_cal(4'b1111, 4'b0001, 2, 0);
    run_cal(4'b1111, 4'b0100, 2, 0);
    run_cal(4'b0000, 4'b1111, 2, 0);
    // R10: stray start mid-sweep
    run_cal(4'b0111, 4'b0000, 3, 1);
    run_cal(4'b1100, 4'b0000, 3, 1);
    // R3 R9: random mix
    for (int r = 0; r < 24; r++)
      run_cal(4'($urandom), ($urandom % 4 == 0) ? 4'(1 << ($urandom % 4)) : 4'b0000,
              1 + ($urandom % TO), ($urandom % 5) == 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule